// File: doc/BRIEF.md
# Register Stack with Wrap-Detected Full and Empty Flags

A last-in first-out store of 64 words, each 16 bits wide, built from registers and addressed by a 6-bit pointer. The pointer always names the word that is currently on top. A push first advances the pointer and then writes the input word at the new address. A pop copies the top word into an output data register and then moves the pointer back by one. Both pointer moves wrap modulo 64.

There is no occupancy counter. Fullness and emptiness are both read from the pointer landing on zero. A push that lands on zero fills the last slot. A pop that lands on zero has removed the last word. After reset the pointer is zero and the stack is empty, so the first word goes to address 1 and address 0 is the last slot filled.

The block refuses a push when full and a pop when empty. A refused request changes nothing and raises a one-cycle error pulse. When push and pop arrive together, the pop is carried out and the push is dropped.

Top module: `lifo_reg_stack`

## Requirements
- R1: While rst_ni is low: sp_o = 0, empty_o = 1, full_o = 0, err_o = 0 and rdata_o = 0.
- R2: A push accepted with pop_i low and full_o low does the following at the clock edge: sp_o becomes sp_o + 1 (mod 64), wdata_i is stored at that new address, and empty_o clears.
- R3: A push with pop_i low while full_o = 1 is refused. sp_o, both flags and the stored words are unchanged, and err_o is 1 for the following cycle.
- R4: A push that moves sp_o to 0 sets full_o. Starting from reset, this is the 64th push, and it writes address 0.
- R5: An accepted pop (empty_o low) does the following: in the following cycle, rdata_o holds the word at the old sp_o, sp_o has become sp_o - 1 (mod 64), and full_o is cleared.
- R6: A pop while empty_o = 1 is refused. sp_o, the flags and rdata_o are unchanged, and err_o is 1 for the following cycle.
- R7: An accepted pop that moves sp_o to 0 sets empty_o.
- R8: When push_i and pop_i are both high, only the pop is considered. The push writes nothing and does not move sp_o, even when the pop itself is refused.
- R9: Words come back out in the reverse of the order in which they were pushed.
- R10: err_o is high only in the cycle after a refused request and is low in every other cycle.
- R11: full_o and empty_o are never high together, and either flag being high implies sp_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle; takes priority over push_i |
| wdata_i | input | 16 | Word to push |
| rdata_o | output | 16 | Data register holding the most recently popped word |
| sp_o | output | 6 | Stack pointer, the address of the top word |
| full_o | output | 1 | All 64 words occupied |
| empty_o | output | 1 | No words stored |
| err_o | output | 1 | One-cycle pulse after a refused push or pop |

## Verification
The hardest state to reach is the full stack, because it takes an unbroken run of 64 accepted pushes.

The bench fills the stack with 64 distinct words and checks the pointer after every push. It then pushes once more while the stack is full. Next it drains all 64 words, which proves two things: the refused word never overwrote slot 0, and the order is last-in first-out all the way to empty.

Simultaneous push and pop are exercised twice. Once on a partly filled stack, where the pop must win. Once on an empty stack, where the pop is refused and the push must still not happen.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_PUSH   = 2'd1,
    OP_POP    = 2'd2,
    OP_REJECT = 2'd3
  } stk_op_e;
endpackage

// File: rtl/lifo_op_arb.sv
module lifo_op_arb
  import lifo_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    full_i,
  input  logic    empty_i,
  output stk_op_e op_o
);
  // pop wins; a losing push is simply dropped
  always_comb begin
    op_o = OP_IDLE;
    if (pop_i) begin
      op_o = empty_i ? OP_REJECT : OP_POP;
    end else if (push_i) begin
      op_o = full_i ? OP_REJECT : OP_PUSH;
    end
  end
endmodule

// File: rtl/lifo_ptr_flags.sv
module lifo_ptr_flags
  import lifo_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  stk_op_e       op_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] sp_inc_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          err_o
);
  localparam logic [AW-1:0] ONE  = AW'(1);
  localparam logic [AW-1:0] ZERO = '0;

  logic [AW-1:0] sp_q, sp_dec;
  logic          full_q, empty_q, err_q;

  assign sp_inc_o = sp_q + ONE;
  assign sp_dec   = sp_q - ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q    <= ZERO;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      err_q <= (op_i == OP_REJECT);
      unique case (op_i)
        OP_PUSH: begin
          sp_q    <= sp_inc_o;
          empty_q <= 1'b0;
          if (sp_inc_o == ZERO) full_q <= 1'b1;
        end
        OP_POP: begin
          sp_q   <= sp_dec;
          full_q <= 1'b0;
          if (sp_dec == ZERO) empty_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign sp_o    = sp_q;
  assign full_o  = full_q;
  assign empty_o = empty_q;
  assign err_o   = err_q;
endmodule

// File: rtl/lifo_store.sv
module lifo_store #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] word_q [DEPTH];
  logic [DW-1:0] dreg_q;

  // per-word enables keep the array as plain flops with no reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (we_i && (waddr_i == AW'(g))) word_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dreg_q <= '0;
    else if (re_i) dreg_q <= word_q[raddr_i];
  end

  assign rdata_o = dreg_q;
endmodule

// File: rtl/lifo_reg_stack.sv
module lifo_reg_stack
  import lifo_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] sp_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          err_o
);
  stk_op_e       op;
  logic [AW-1:0] sp, sp_inc;
  logic          full, empty;

  lifo_op_arb u_arb (
    .push_i  (push_i),
    .pop_i   (pop_i),
    .full_i  (full),
    .empty_i (empty),
    .op_o    (op)
  );

  lifo_ptr_flags #(.AW(AW)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .sp_o     (sp),
    .sp_inc_o (sp_inc),
    .full_o   (full),
    .empty_o  (empty),
    .err_o    (err_o)
  );

  lifo_store #(.DW(DW), .AW(AW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (op == OP_PUSH),
    .waddr_i (sp_inc),
    .wdata_i (wdata_i),
    .re_i    (op == OP_POP),
    .raddr_i (sp),
    .rdata_o (rdata_o)
  );

  assign sp_o    = sp;
  assign full_o  = full;
  assign empty_o = empty;
endmodule

// File: rtl/lifo_reg_stack_chk.sv
module lifo_reg_stack_chk #(
  parameter int unsigned AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic          pop_i,
  input logic [AW-1:0] sp_o,
  input logic          full_o,
  input logic          empty_o,
  input logic          err_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  assert_push_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full_o) |=> (sp_o == $past(sp_o) + ONE) && !empty_o);

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full_o) |=> err_o && full_o && $stable(sp_o));

  assert_pop_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty_o) |=> (sp_o == $past(sp_o) - ONE) && !full_o);

  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o) |=> err_o && empty_o && $stable(sp_o));

  assert_err_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(pop_i ? empty_o : (push_i && full_o)));

  assert_flags_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  assert_flag_ptr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o || empty_o) |-> (sp_o == '0));
endmodule

bind lifo_reg_stack lifo_reg_stack_chk #(.AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .push_i  (push_i),
  .pop_i   (pop_i),
  .sp_o    (sp_o),
  .full_o  (full_o),
  .empty_o (empty_o),
  .err_o   (err_o)
);

// File: tb/tb_lifo_reg_stack.sv
module tb_lifo_reg_stack;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        push_i, pop_i;
  logic [15:0] wdata_i;
  logic [15:0] rdata_o;
  logic [5:0]  sp_o;
  logic        full_o, empty_o, err_o;

  always #4 clk_i = ~clk_i;

  lifo_reg_stack dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .sp_o    (sp_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .err_o   (err_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [15:0] m_mem [64];
  logic [5:0]  m_sp;
  logic        m_full, m_empty, m_err;
  logic [15:0] m_rdata;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sp = 0; m_full = 0; m_empty = 1; m_err = 0; m_rdata = 0;
  endtask

  task automatic compare(string req);
    chk(req, "sp", sp_o, m_sp);
    chk(req, "full", full_o, m_full);
    chk(req, "empty", empty_o, m_empty);
    chk(req, "err", err_o, m_err);
    chk(req, "rdata", rdata_o, m_rdata);
    chk("R11", "flags both set", int'(full_o && empty_o), 0);
  endtask

  // called at a falling edge; applies one cycle of stimulus, checks at next falling edge
  task automatic step(bit ps, bit pp, logic [15:0] d, string req);
    push_i = ps; pop_i = pp; wdata_i = d;
    m_err = 1'b0;
    if (pp) begin
      if (m_empty) m_err = 1'b1;
      else begin
        m_rdata = m_mem[m_sp];
        m_sp    = m_sp - 6'd1;
        m_full  = 1'b0;
        if (m_sp == 0) m_empty = 1'b1;
      end
    end else if (ps) begin
      if (m_full) m_err = 1'b1;
      else begin
        m_sp = m_sp + 6'd1;
        m_mem[m_sp] = d;
        m_empty = 1'b0;
        if (m_sp == 0) m_full = 1'b1;
      end
    end
    @(negedge clk_i);
    compare(req);
  endtask

  task automatic test_reset();
    rst_ni = 1'b0; push_i = 0; pop_i = 0; wdata_i = 0;
    model_reset();
    repeat (2) @(negedge clk_i);
    compare("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1");
  endtask

  task automatic test_fill();
    for (int i = 0; i < 63; i++) step(1, 0, 16'h1000 + 16'(i), "R2");
    chk("R4", "full before last", full_o, 0);
    step(1, 0, 16'hC0DE, "R4");
    chk("R4", "full after 64", full_o, 1);
  endtask

  task automatic test_overflow();
    step(1, 0, 16'hDEAD, "R3");
    step(0, 0, 16'h0, "R10");
  endtask

  task automatic test_drain();
    step(0, 1, 16'h0, "R5");
    chk("R9", "top after refused push", rdata_o, 16'hC0DE);
    for (int i = 0; i < 63; i++) step(0, 1, 16'h0, "R9");
    chk("R7", "empty after drain", empty_o, 1);
  endtask

  task automatic test_underflow();
    step(0, 1, 16'h0, "R6");
    step(0, 0, 16'h0, "R10");
    step(0, 1, 16'h0, "R6");
  endtask

  task automatic test_both();
    step(1, 1, 16'hBAD0, "R8");
    step(1, 0, 16'hAAAA, "R2");
    step(1, 0, 16'hBBBB, "R2");
    step(1, 0, 16'hCCCC, "R2");
    step(1, 1, 16'hBAD1, "R8");
    step(1, 0, 16'hDDDD, "R8");
    step(0, 1, 16'h0, "R8");
    step(0, 1, 16'h0, "R9");
    step(0, 1, 16'h0, "R7");
    step(0, 0, 16'h0, "R10");
  endtask

  initial begin
    @(negedge clk_i);
    test_reset();
    test_fill();
    test_overflow();
    test_drain();
    test_underflow();
    test_both();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule